// File: doc/BRIEF.md
# Per-Row-Pair SDRAM Clock-Enable Power-Down Controller

This block drives one clock-enable line for each pair of SDRAM rows and lowers it when that pair has nothing to do. The scheduler reports, pair by pair, whether all banks are closed. Once a closed pair has also been left alone for long enough, the block drops its clock-enable. A single enable input gates the feature for every pair. While the enable is low, every clock-enable line is held high.

The command scheduler presents one access at a time: a valid flag plus the index of the row pair it targets. If that pair is awake and settled, a ready output goes high in the same cycle. If the pair is asleep, the block first raises its clock-enable. It then holds ready low for a fixed exit latency before it lets the access through. Each pair keeps its own power state, so a wake-up on one pair leaves the others untouched.

Top module: `cke_pdown_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, every bit of `cke` is 1 and `req_ready` is 0 while `req_valid` is 0.
- R2: While `pd_en` is 0, every bit of `cke` stays 1, whatever `all_pre` shows.
- R3: With `pd_en` = 1, a pair whose `all_pre` bit is 1 with no request to it drops its `cke` bit only after this condition has been sampled at two consecutive rising edges. The bit is still 1 after the first of those edges and is 0 after the second.
- R4: A request that targets a pair (`req_valid` = 1 and `req_pair` equal to that pair's index) keeps that pair's `cke` high, even while its `all_pre` bit is 1.
- R5: Each pair has its own power state. Entry or exit on one pair does not change any other pair's `cke` bit.
- R6: A request to a pair whose `cke` bit is 0 sets that bit to 1 at the next rising edge.
- R7: After a wake-up edge, `req_ready` stays 0 for that pair for EXIT_LAT further rising edges and becomes 1 after the EXIT_LAT-th of them, provided the request is still held.
- R8: A request to a pair whose `cke` is 1 and which is not in an exit delay sees `req_ready` = 1 in the same cycle, with no clock in between.
- R9: If `pd_en` goes from 1 to 0 while some pairs are powered down, every `cke` bit is 1 after the next rising edge.
- R10: If a pair's `all_pre` bit is high at only one edge and low at the next, the pair does not enter power-down. The idle qualification starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_en | input | 1 | Enables dynamic power-down for all pairs |
| all_pre | input | NPAIRS | Per pair: 1 when all banks of that pair are closed |
| req_valid | input | 1 | An access is pending |
| req_pair | input | IW | Index of the row pair the access targets |
| req_ready | output | 1 | The pending access may be issued this cycle |
| cke | output | NPAIRS | Registered clock-enable, one bit per row pair |

## Verification
The assertions assume that `req_pair` always names an existing pair, and that the scheduler holds a request steady until it sees ready. The ready-latency check depends on the second of these. The bench keeps to the default of four pairs, so every index it drives is legal. Its wake-up scenario holds `req_valid` and `req_pair` unchanged through the whole exit delay and drops the request only after ready has been observed.

// File: rtl/cke_pdown_ctrl.sv
module cke_pdown_ctrl #(
  parameter int NPAIRS   = 4,
  parameter int EXIT_LAT = 2,
  localparam int IW = (NPAIRS < 2) ? 1 : $clog2(NPAIRS),
  localparam int CW = (EXIT_LAT < 1) ? 1 : $clog2(EXIT_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_en,
  input  logic [NPAIRS-1:0] all_pre,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_pair,
  output logic              req_ready,
  output logic [NPAIRS-1:0] cke
);

  logic [NPAIRS-1:0] cke_q, armed;
  logic [CW-1:0]     wait_cnt [NPAIRS];

  assign cke       = cke_q;
  assign req_ready = req_valid && cke_q[req_pair] && (wait_cnt[req_pair] == '0);

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    logic hit, idle;
    assign hit  = req_valid && (req_pair == IW'(i));
    assign idle = pd_en && all_pre[i] && !hit && cke_q[i] && (wait_cnt[i] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cke_q[i]    <= 1'b1;
        armed[i]    <= 1'b0;
        wait_cnt[i] <= '0;
      end else begin
        armed[i] <= idle;
        if (!cke_q[i] && (hit || !pd_en)) begin
          cke_q[i]    <= 1'b1;
          wait_cnt[i] <= CW'(EXIT_LAT);
        end else begin
          if (idle && armed[i]) cke_q[i] <= 1'b0;
          if (wait_cnt[i] != '0) wait_cnt[i] <= wait_cnt[i] - 1'b1;
        end
      end
    end

    p_entry_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_q[i]) |-> $past(pd_en) && $past(all_pre[i]));
    p_no_entry_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_q[i]) |-> !$past(req_valid && (req_pair == IW'(i))));
    p_wake_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_q[i] && req_valid && (req_pair == IW'(i))) |=> cke_q[i]);
    p_exit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cke_q[i]) && req_valid && (req_pair == IW'(i))) |-> !req_ready);
  end

  p_disabled_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en |=> (&cke_q));
  p_ready_needs_cke_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cke_q[req_pair]);

endmodule

// File: tb/sim_cke_pdown_ctrl.sv
`timescale 1ns/1ps
module sim_cke_pdown_ctrl;
  localparam int NP = 4;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0, pd_en = 0, req_valid = 0;
  logic [NP-1:0] all_pre = '0;
  logic [1:0] req_pair = '0;
  logic req_ready;
  logic [NP-1:0] cke;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cke_pdown_ctrl #(.NPAIRS(NP), .EXIT_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .all_pre(all_pre),
    .req_valid(req_valid), .req_pair(req_pair), .req_ready(req_ready), .cke(cke));

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; pd_en = 0; all_pre = '0; req_valid = 0; req_pair = '0;
    tick; tick;
    chk(cke == 4'hF, "R1 cke during reset", cke, 4'hF);
    rst_n = 1; tick;
    chk(cke == 4'hF, "R1 cke after reset", cke, 4'hF);
    chk(req_ready == 0, "R1 ready idle", req_ready, 0);
  endtask

  task automatic t_disabled;
    do_reset;
    all_pre = 4'hF;
    for (int k = 0; k < 5; k++) begin
      tick;
      chk(cke == 4'hF, "R2 disabled stays awake", cke, 4'hF);
    end
  endtask

  task automatic t_entry_wake;
    do_reset;
    pd_en = 1; all_pre = 4'b0001;
    tick;
    chk(cke[0] == 1, "R3 not after first edge", cke[0], 1);
    tick;
    chk(cke[0] == 0, "R3 down after second edge", cke[0], 0);
    chk(cke[3:1] == 3'b111, "R5 others unaffected", cke[3:1], 3'b111);
    req_valid = 1; req_pair = 0; #1;
    chk(req_ready == 0, "R7 ready low while asleep", req_ready, 0);
    tick;
    chk(cke == 4'hF, "R6 wake on request", cke, 4'hF);
    chk(req_ready == 0, "R7 ready low on wake", req_ready, 0);
    for (int j = 1; j <= LAT; j++) begin
      tick;
      chk(req_ready == (j == LAT), "R7 exit latency", req_ready, (j == LAT));
    end
    req_valid = 0;
  endtask

  task automatic t_pending;
    do_reset;
    pd_en = 1; all_pre = 4'b0010; req_valid = 1; req_pair = 1; #1;
    chk(req_ready == 1, "R8 ready same cycle", req_ready, 1);
    for (int k = 0; k < 4; k++) begin
      tick;
      chk(cke[1] == 1, "R4 request blocks entry", cke[1], 1);
    end
    req_valid = 0;
  endtask

  task automatic t_glitch;
    do_reset;
    pd_en = 1;
    all_pre = 4'b0100; tick;
    all_pre = 4'b0000; tick;
    chk(cke[2] == 1, "R10 single edge idle", cke[2], 1);
    all_pre = 4'b0100; tick;
    chk(cke[2] == 1, "R10 restart qualification", cke[2], 1);
    all_pre = 4'b0000; tick;
    chk(cke[2] == 1, "R10 no entry", cke[2], 1);
  endtask

  task automatic t_disable_wake;
    do_reset;
    pd_en = 1; all_pre = 4'b1001;
    tick; tick;
    chk(cke == 4'b0110, "R5 two pairs down", cke, 4'b0110);
    pd_en = 0; tick;
    chk(cke == 4'hF, "R9 disable wakes all", cke, 4'hF);
  endtask

  initial begin
    t_disabled;
    t_entry_wake;
    t_pending;
    t_glitch;
    t_disable_wake;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule